// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers six interrupt requests (two external pins, three timers and one serial channel whose receive and transmit flags share a slot). It masks them with per-source enables and a global enable, picks one winner by priority level and by a fixed poll order, and offers the winner to a CPU core as a 16-bit vector address. The offer is made only when the core signals an instruction boundary.

The core takes the offer with a one-cycle acknowledge. From then on the block records the winner's priority level as in service. Only a strictly higher level can interrupt a handler that is running. A return strobe from the core ends the most recent handler, which puts the level that was in service before it back in force. A one-hot pulse tells the chosen source that its request was taken.

Two priority schemes are available through a parameter. The two-level scheme uses one priority register. The four-level scheme pairs a high register with the low register.

Top module: `pvic_top`

## Requirements
- R1: After reset every enable bit is 0, and no vector is offered for any request pattern, even when only the global enable bit (bit 7) is then written.
- R2: While global enable bit 7 is 0, no vector is offered, whatever per-source enable bits 5..0 hold.
- R3: Enable bit i (0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2) masks request i when it is 0.
- R4: The vector address of source i is 0x0003 + 8*i (0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B).
- R5: A vector is offered only in the cycle after an instruction-boundary strobe. Its valid flag and address then stay unchanged until the core acknowledges, whatever the requests do in between.
- R6: Among pending requests of equal level, the lowest source index wins.
- R7: A source whose low-priority bit (same bit position as its enable) is 1 beats any level-0 request, regardless of poll order.
- R8: Serial receive (request bit 4) and serial transmit (separate input) are ORed into slot 4, with vector 0x0023.
- R9: One cycle after the acknowledge, the valid flag drops and the source-acknowledge output pulses for one cycle with only the taken source's bit set.
- R10: While a handler is in service, a request of strictly higher level is offered at the next boundary. A request of equal or lower level is held off.
- R11: In two-level mode, no request is offered while a level-1 handler is in service, and writes to the high priority register have no effect.
- R12: The return strobe releases the highest in-service level only. Requests held off by the remaining in-service level stay held off until a further return.
- R13: In four-level mode, a source's level is {high bit, low bit}, 3 highest. Only a strictly higher level preempts, through up to three nested levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 6 | Request per source; bit 4 is serial receive |
| ser_tx_i | input | 1 | Serial transmit flag, ORed into slot 4 |
| en_we_i | input | 1 | Write strobe for the enable register |
| plo_we_i | input | 1 | Write strobe for the low priority register |
| phi_we_i | input | 1 | Write strobe for the high priority register (four-level mode) |
| wdata_i | input | 8 | Register write data |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| vec_valid_o | output | 1 | A vector is offered |
| vec_addr_o | output | 16 | Offered vector address |
| vec_ack_i | input | 1 | Core takes the offered vector |
| src_ack_o | output | 6 | One-cycle one-hot pulse to the taken source |
| reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
Some rules are checked on every cycle by the embedded properties: no offer appears without a boundary strobe or while the global enable is off, an offer holds steady until it is acknowledged, the source-acknowledge output is one-hot, and each acknowledge marks a level at least as high as the taken one as in service. The directed scenarios are what show that the right source wins. They cover the address table, poll-order ties, priority over poll order and the merged serial slot. They also cover nesting and release: equal-level hold-off, strict-level preemption, the two-level ceiling, and return strobes that restore the earlier level one step at a time.

// File: rtl/pvic_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes six sources in a fixed poll order, index 0 polled first.
package pvic_pkg;
    localparam int LVL_W   = 2;    // wide enough for four levels
    localparam int SER_IDX = 4;    // slot shared by serial receive and transmit
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pvic_regs.sv
// Enable and priority registers plus per-source level mapping.
// Assumes enable bit DATA_W-1 is the global enable and bits NUM_SRC-1..0
// are per-source. FOUR_LEVEL selects whether a high priority register exists.
module pvic_regs
    import pvic_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int DATA_W     = 8,
    parameter bit FOUR_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we_i,
    input  logic              plo_we_i,
    input  logic              phi_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              gie_o,
    output logic [NUM_SRC-1:0] src_en_o,
    output lvl_t              src_lvl_o [NUM_SRC]
);
    localparam int GIE_BIT = DATA_W - 1;

    logic [NUM_SRC-1:0] plo_q;
    logic [NUM_SRC-1:0] phi_q;
    logic               unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-2:NUM_SRC];

    // Global and per-source enables; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o    <= 1'b0;
            src_en_o <= '0;
        end else if (en_we_i) begin
            gie_o    <= wdata_i[GIE_BIT];
            src_en_o <= wdata_i[NUM_SRC-1:0];
        end
    end

    // Low priority register, used in both modes.
    always_ff @(posedge clk) begin
        if (!rst_n)        plo_q <= '0;
        else if (plo_we_i) plo_q <= wdata_i[NUM_SRC-1:0];
    end

    generate
        if (FOUR_LEVEL) begin : g_four
            // High priority register, present only in four-level mode.
            always_ff @(posedge clk) begin
                if (!rst_n)        phi_q <= '0;
                else if (phi_we_i) phi_q <= wdata_i[NUM_SRC-1:0];
            end
        end else begin : g_two
            logic unused_phi_we;
            assign unused_phi_we = phi_we_i;
            assign phi_q = '0;
        end
    endgenerate

    // Level of each source: {high bit, low bit}.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            src_lvl_o[i] = {phi_q[i], plo_q[i]};
        end
    end
endmodule

// File: rtl/pvic_arbiter.sv
// Combinational winner selection: highest level first, lowest index on ties.
// The winner is eligible only when nothing is in service or its level is
// strictly above the current in-service level.
module pvic_arbiter
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  lvl_t               lvl_i [NUM_SRC],
    input  logic               busy_i,
    input  lvl_t               cur_lvl_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o,
    output lvl_t               lvl_o
);
    logic found;

    // Scan in poll order; a later source wins only with a strictly higher level.
    always_comb begin
        found = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && (!found || (lvl_i[i] > lvl_o))) begin
                found = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = lvl_i[i];
            end
        end
        hit_o = found && (!busy_i || (lvl_o > cur_lvl_i));
    end
endmodule

// File: rtl/pvic_service.sv
// Vector offer/acknowledge handshake and in-service level tracking.
// Assumes the core holds vec_ack_i for one cycle per taken vector and pulses
// reti_i once per finished handler.
module pvic_service
    import pvic_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int IDX_W      = 3,
    parameter int NLVL       = 2,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic               hit_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  lvl_t               lvl_i,
    input  logic               vec_ack_i,
    input  logic               reti_i,
    output logic               vec_valid_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic [NUM_SRC-1:0] src_ack_o,
    output logic               busy_o,
    output lvl_t               cur_lvl_o
);
    logic [IDX_W-1:0] idx_q;
    lvl_t             lvl_q;
    logic [NLVL-1:0]  ins_q;
    logic [NLVL-1:0]  set_mask;
    logic [NLVL-1:0]  clr_mask;
    logic             take;

    assign take       = vec_valid_o && vec_ack_i;
    assign vec_addr_o = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(idx_q));

    // Highest in-service level and the masks for acknowledge and return.
    always_comb begin
        busy_o    = |ins_q;
        cur_lvl_o = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (ins_q[l]) cur_lvl_o = lvl_t'(l);
        end
        for (int l = 0; l < NLVL; l++) begin
            set_mask[l] = take && (lvl_q == lvl_t'(l));
            clr_mask[l] = reti_i && busy_o && (cur_lvl_o == lvl_t'(l));
        end
    end

    // Latch an offer at a boundary; drop it when the core takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_o <= 1'b0;
            idx_q       <= '0;
            lvl_q       <= '0;
        end else if (take) begin
            vec_valid_o <= 1'b0;
        end else if (!vec_valid_o && boundary_i && hit_i) begin
            vec_valid_o <= 1'b1;
            idx_q       <= idx_i;
            lvl_q       <= lvl_i;
        end
    end

    // In-service levels: set on acknowledge, highest cleared on return.
    always_ff @(posedge clk) begin
        if (!rst_n) ins_q <= '0;
        else        ins_q <= (ins_q & ~clr_mask) | set_mask;
    end

    // One-cycle one-hot notice to the taken source.
    always_ff @(posedge clk) begin
        if (!rst_n)    src_ack_o <= '0;
        else if (take) src_ack_o <= NUM_SRC'(1) << idx_q;
        else           src_ack_o <= '0;
    end

    // R5
    no_offer_without_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid_o && !boundary_i) |=> !vec_valid_o);

    // R5
    offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !vec_ack_i) |=> (vec_valid_o && $stable(vec_addr_o)));

    // R9
    src_ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack_o));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ($countones(src_ack_o) == 1 && !vec_valid_o));

    // R10
    ack_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy_o && (cur_lvl_o >= $past(lvl_q))));
endmodule

// File: rtl/pvic_top.sv
// Prioritized vectored interrupt controller top level.
// Merges the serial transmit flag into the serial slot, masks requests with
// the enables, and connects registers, arbiter and handshake/service logic.
module pvic_top
    import pvic_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    parameter bit FOUR_LEVEL = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               ser_tx_i,
    input  logic               en_we_i,
    input  logic               plo_we_i,
    input  logic               phi_we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               boundary_i,
    output logic               vec_valid_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    input  logic               vec_ack_i,
    output logic [NUM_SRC-1:0] src_ack_o,
    input  logic               reti_i
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int NLVL  = FOUR_LEVEL ? 4 : 2;

    logic               gie;
    logic [NUM_SRC-1:0] src_en;
    lvl_t               src_lvl [NUM_SRC];
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] pend;
    logic               hit;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl;
    logic               busy;
    lvl_t               cur_lvl;

    // Serial transmit joins the serial receive slot; then apply the enables.
    always_comb begin
        raw_req          = req_i;
        raw_req[SER_IDX] = req_i[SER_IDX] | ser_tx_i;
        pend             = raw_req & src_en & {NUM_SRC{gie}};
    end

    pvic_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .FOUR_LEVEL(FOUR_LEVEL)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we_i  (en_we_i),
        .plo_we_i (plo_we_i),
        .phi_we_i (phi_we_i),
        .wdata_i  (wdata_i),
        .gie_o    (gie),
        .src_en_o (src_en),
        .src_lvl_o(src_lvl)
    );

    pvic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .pend_i   (pend),
        .lvl_i    (src_lvl),
        .busy_i   (busy),
        .cur_lvl_i(cur_lvl),
        .hit_o    (hit),
        .idx_o    (win_idx),
        .lvl_o    (win_lvl)
    );

    pvic_service #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .NLVL(NLVL), .ADDR_W(ADDR_W),
        .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary_i),
        .hit_i      (hit),
        .idx_i      (win_idx),
        .lvl_i      (win_lvl),
        .vec_ack_i  (vec_ack_i),
        .reti_i     (reti_i),
        .vec_valid_o(vec_valid_o),
        .vec_addr_o (vec_addr_o),
        .src_ack_o  (src_ack_o),
        .busy_o     (busy),
        .cur_lvl_o  (cur_lvl)
    );

    // R2
    global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && !vec_valid_o) |=> !vec_valid_o);
endmodule

// File: tb/tb_pvic_top.sv
// Directed bench: dut runs four-level mode, dut2 runs two-level mode,
// both fed the same stimulus.
module tb_pvic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req = '0;
    logic        ser_tx = 1'b0;
    logic        en_we = 1'b0, plo_we = 1'b0, phi_we = 1'b0;
    logic [7:0]  wdata = '0;
    logic        boundary = 1'b0, vec_ack = 1'b0, reti = 1'b0;
    logic        vv, vv2;
    logic [15:0] va, va2;
    logic [5:0]  sa, sa2;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    pvic_top #(.FOUR_LEVEL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ser_tx_i(ser_tx),
        .en_we_i(en_we), .plo_we_i(plo_we), .phi_we_i(phi_we), .wdata_i(wdata),
        .boundary_i(boundary), .vec_valid_o(vv), .vec_addr_o(va),
        .vec_ack_i(vec_ack), .src_ack_o(sa), .reti_i(reti)
    );

    pvic_top #(.FOUR_LEVEL(1'b0)) dut2 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ser_tx_i(ser_tx),
        .en_we_i(en_we), .plo_we_i(plo_we), .phi_we_i(phi_we), .wdata_i(wdata),
        .boundary_i(boundary), .vec_valid_o(vv2), .vec_addr_o(va2),
        .vec_ack_i(vec_ack), .src_ack_o(sa2), .reti_i(reti)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic do_reset();
        req = '0; ser_tx = 0; en_we = 0; plo_we = 0; phi_we = 0;
        boundary = 0; vec_ack = 0; reti = 0; rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic wr_en(logic [7:0] v);  wdata = v; en_we = 1;  tick(); en_we = 0;  endtask
    task automatic wr_lo(logic [7:0] v);  wdata = v; plo_we = 1; tick(); plo_we = 0; endtask
    task automatic wr_hi(logic [7:0] v);  wdata = v; phi_we = 1; tick(); phi_we = 0; endtask
    task automatic bnd();                 boundary = 1; tick(); boundary = 0; endtask
    task automatic ret();                 reti = 1; tick(); reti = 0; endtask

    // Expect an offer of addr on the chosen instance, take it, check the notice.
    task automatic take(string tag, bit two, int addr, int ackv);
        chk({tag, " valid"}, two ? vv2 : vv, 1);
        chk({tag, " addr"}, two ? va2 : va, addr);
        vec_ack = 1; tick(); vec_ack = 0;
        chk({tag, " valid drop"}, two ? vv2 : vv, 0);
        chk({tag, " src_ack"}, two ? sa2 : sa, ackv);
        tick();
        chk({tag, " src_ack end"}, two ? sa2 : sa, 0);
    endtask

    task automatic t_reset();   // R1
        do_reset();
        chk("R1 valid after reset", vv, 0);
        chk("R1 src_ack after reset", sa, 0);
        req = 6'h3F; ser_tx = 1; bnd();
        chk("R1 no offer all masked", vv, 0);
        wr_en(8'h80); bnd();
        chk("R1 global only no offer", vv, 0);
    endtask

    task automatic t_global();  // R2
        do_reset();
        wr_en(8'h3F); req = 6'h01; bnd();
        chk("R2 global off no offer", vv, 0);
        wr_en(8'hBF); bnd();
        take("R2 global on", 0, 16'h0003, 6'h01);
        req = 0; ret();
    endtask

    task automatic t_mask();    // R3
        do_reset();
        wr_en(8'hBD); req = 6'h02; bnd();
        chk("R3 masked timer0", vv, 0);
        req = 6'h0A; bnd();
        take("R3 timer1 passes", 0, 16'h001B, 6'h08);
        req = 0; ret();
    endtask

    task automatic t_vectors(); // R4
        do_reset();
        wr_en(8'hBF);
        for (int i = 0; i < 6; i++) begin
            req = 6'(1 << i); bnd();
            take($sformatf("R4 slot %0d", i), 0, 3 + 8 * i, 1 << i);
            req = 0; ret();
        end
    endtask

    task automatic t_boundary(); // R5
        do_reset();
        wr_en(8'h81); req = 6'h01;
        tick(); tick(); tick();
        chk("R5 no boundary no offer", vv, 0);
        bnd();
        req = 6'h00; wr_en(8'hBF); req = 6'h3F; tick(); tick();
        chk("R5 held valid", vv, 1);
        chk("R5 held addr", va, 16'h0003);
        take("R5 take", 0, 16'h0003, 6'h01);
        req = 0; ret();
    endtask

    task automatic t_poll();    // R6
        do_reset();
        wr_en(8'hBF);
        for (int i = 0; i < 6; i++) begin
            req = 6'h3F << i; bnd();
            take($sformatf("R6 tie from %0d", i), 0, 3 + 8 * i, 1 << i);
            req = 0; ret();
        end
    endtask

    task automatic t_prio();    // R7
        do_reset();
        wr_en(8'hBF); wr_lo(8'h20); req = 6'h3F; bnd();
        take("R7 timer2 high", 0, 16'h002B, 6'h20);
        ret();
        wr_lo(8'h18); bnd();
        take("R7 timer1 first of high", 0, 16'h001B, 6'h08);
        req = 0; ret();
    endtask

    task automatic t_serial();  // R8
        do_reset();
        wr_en(8'h90); ser_tx = 1; bnd();
        take("R8 transmit", 0, 16'h0023, 6'h10);
        ser_tx = 0; ret();
        req = 6'h10; bnd();
        take("R8 receive", 0, 16'h0023, 6'h10);
        req = 0; ret();
    endtask

    task automatic t_nest();    // R10, R12
        do_reset();
        wr_en(8'hBF); wr_lo(8'h08);
        req = 6'h01; bnd();
        take("R10 ext0 low", 0, 16'h0003, 6'h01);
        req = 6'h04; bnd();
        chk("R10 equal level held", vv, 0);
        req = 6'h0C; bnd();
        take("R10 timer1 preempts", 0, 16'h001B, 6'h08);
        req = 6'h04; ret(); bnd();
        chk("R12 level0 still in service", vv, 0);
        ret(); bnd();
        take("R12 after second return", 0, 16'h0013, 6'h04);
        req = 0; ret();
    endtask

    task automatic t_two();     // R11
        do_reset();
        wr_en(8'h83); wr_lo(8'h03);
        req = 6'h02; bnd();
        take("R11 timer0 high", 1, 16'h000B, 6'h02);
        req = 6'h01; bnd();
        chk("R11 high not preempted", vv2, 0);
        wr_hi(8'h01); bnd();
        chk("R11 high reg ignored", vv2, 0);
        ret(); bnd();
        take("R11 after return", 1, 16'h0003, 6'h01);
        req = 0; ret();
    endtask

    task automatic t_four();    // R13
        do_reset();
        wr_en(8'hA3); wr_lo(8'h21); wr_hi(8'h22);
        req = 6'h01; bnd();
        take("R13 level1", 0, 16'h0003, 6'h01);
        req = 6'h02; bnd();
        take("R13 level2 preempts", 0, 16'h000B, 6'h02);
        req = 6'h20; bnd();
        take("R13 level3 preempts", 0, 16'h002B, 6'h20);
        bnd();
        chk("R13 equal level3 held", vv, 0);
        ret(); bnd();
        take("R13 level3 over restored level2", 0, 16'h002B, 6'h20);
        req = 0; ret(); ret(); ret();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_global();
        t_mask();
        t_vectors();
        t_boundary();
        t_poll();
        t_prio();
        t_serial();
        t_nest();
        t_two();
        t_four();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule